// File: doc/BRIEF.md
# Two-Wire Debug Pin Pair Scanner

This block finds which two pins of an unmarked pin bank carry a two-wire serial debug port. When started, it works through ordered pin pairs, treating the first pin of each pair as the debug clock and the second as the bidirectional data line. For each pair it attaches a small host engine to those two pins and leaves every other pin undriven. The engine sends a line-reset and protocol-select preamble, followed by a read of the debug port's identification register, and judges the reply. The scan stops at the first pair whose reply is acceptable. It then reports the two pin indices and the 32-bit identification word.

The pins are assumed to have external pull-ups, so a released pin reads high. The clock pin is driven in both directions. The data pin is only ever pulled low or released. Each bit of the host engine lasts two cycles of `clk`: the clock pin is low for the first cycle and high for the second. The host changes data at the start of the low half. It samples the data line at the clock edge that ends the low half. A target is expected to update its data right after each rising edge of the debug clock.

Top module: `dbg_pair_scanner`

## Requirements
- R1: After reset, `done` and `found` are low, `id_value` is zero and no pin is output-enabled.
- R2: Pairs are tried in a fixed order. The clock index is the outer loop and the data index is the inner loop, both ascending from 0, and pairs with equal indices are skipped. The first passing pair is reported on `clk_idx` and `dat_idx`, so the pair with rank clk*(n-1)+(dat<clk ? dat : dat-1) is found at trial number rank+1.
- R3: During a trial at most two pins are enabled. The clock pin is enabled for the whole trial and drives low then high in each bit. The data pin is enabled only while it drives 0. All other pins stay released.
- R4: Each trial sends the following, all bits least significant first: RESET_BITS ones (at least 50), the 16-bit select word 0xE79E, RESET_BITS ones, IDLE_BITS zeros, and the request byte 0xA5 (identification read of the debug port, register 0). After that, one turnaround bit is spent with the data line released.
- R5: The three acknowledge bits are received least significant first. Only the value 3'b001 (first received bit 1, other two 0) counts as OK. WAIT (3'b010), FAULT (3'b100) or any other value fails the pair.
- R6: The 32 identification bits are received least significant first, followed by one parity bit. The pair fails unless the parity bit equals the XOR of the 32 data bits.
- R7: An identification word of all zeros or all ones fails the pair even with an OK acknowledge.
- R8: Before each trial, including the first, all pins are released for at least `settle_cycles` cycles.
- R9: If no pair passes, `done` rises with `found` low and `id_value` zero, after n*(n-1) trials.
- R10: A `pin_count` below 2 ends the scan at once with `found` low and no trial. A `pin_count` above NPINS is treated as NPINS.
- R11: `start` is ignored while a scan runs, and `pin_count` is captured only at start. Once `done` is raised, `done`, `found`, `id_value` and the indices hold until the next `start`.
- R12: While `done` is high, no pin is output-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one debug bit spans two cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a scan when idle or done |
| pin_count | input | PCW | Number of bank pins to search, captured at start |
| settle_cycles | input | SETTLE_W | Release time before each trial |
| pin_in | input | NPINS | Sampled levels of the bank pins |
| pin_oe | output | NPINS | Per-pin output enable |
| pin_out | output | NPINS | Per-pin output value |
| done | output | 1 | Scan finished |
| found | output | 1 | A pair passed |
| clk_idx | output | IDXW | Clock pin index of the reported pair |
| dat_idx | output | IDXW | Data pin index of the reported pair |
| id_value | output | 32 | Captured identification word, zero when not found |

## Verification
A wrong pair counter shows up as a wrong trial count or wrong reported indices as soon as the scan ends. The bench counts trials at the pins to catch this. A wrong bit index or sampling phase in the engine causes a correct target model to ignore the request or return misaligned bits. Such a fault turns an expected pass into a failure or a corrupted word within one trial of about 350 cycles. Drive faults are visible on the very cycle they occur, for example an extra enabled pin or a data pin driven high.

// File: rtl/dps_pkg.sv
package dps_pkg;
   typedef enum logic [2:0] {
      SC_IDLE,
      SC_SETTLE,
      SC_PROBE,
      SC_JUDGE,
      SC_DONE
   } scan_state_t;

   localparam logic [15:0] SEL_SEQ        = 16'hE79E;
   localparam logic [7:0]  ID_REQ         = 8'hA5;
   localparam logic [2:0]  ACK_OK         = 3'b001;
   localparam int          MIN_RESET_BITS = 50;
   localparam int          ID_W           = 32;
endpackage

// File: rtl/dps_pair_cnt.sv
module dps_pair_cnt #(
   parameter int NPINS = 8,
   parameter int IDXW  = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic            adv,
   input  logic [IDXW:0]   n,
   output logic [IDXW-1:0] c,
   output logic [IDXW-1:0] d,
   output logic            last
);
   logic [IDXW:0] c_e, nc, nd;
   logic          wrap;

   always_comb begin
      c_e = {1'b0, c};
      nd  = {1'b0, d} + 1'b1;
      if (nd == c_e) nd = nd + 1'b1;
      wrap = (nd >= n);
      nc   = c_e;
      if (wrap) begin
         nc = c_e + 1'b1;
         nd = '0;
      end
      last = wrap && (c_e == n - 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c <= '0;
         d <= '0;
      end else if (load) begin
         c <= '0;
         d <= IDXW'(1);
      end else if (adv) begin
         c <= nc[IDXW-1:0];
         d <= nd[IDXW-1:0];
      end
   end
endmodule

// File: rtl/dps_probe.sv
module dps_probe
   import dps_pkg::*;
#(
   parameter int RESET_BITS = 56,
   parameter int IDLE_BITS  = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic            sdi,
   output logic            active,
   output logic            sclk,
   output logic            sdo_low,
   output logic            fin,
   output logic [2:0]      ack,
   output logic [ID_W-1:0] id,
   output logic            par
);
   localparam int P_SEL  = RESET_BITS;
   localparam int P_RST2 = P_SEL + 16;
   localparam int P_IDLE = P_RST2 + RESET_BITS;
   localparam int P_REQ  = P_IDLE + IDLE_BITS;
   localparam int P_TRN  = P_REQ + 8;
   localparam int P_ACK  = P_TRN + 1;
   localparam int P_DAT  = P_ACK + 3;
   localparam int P_PAR  = P_DAT + ID_W;
   localparam int P_END  = P_PAR + 2;
   localparam int BW     = $clog2(P_END + 1);

   localparam logic [BW-1:0] B_SEL  = BW'(P_SEL);
   localparam logic [BW-1:0] B_RST2 = BW'(P_RST2);
   localparam logic [BW-1:0] B_IDLE = BW'(P_IDLE);
   localparam logic [BW-1:0] B_REQ  = BW'(P_REQ);
   localparam logic [BW-1:0] B_TRN  = BW'(P_TRN);
   localparam logic [BW-1:0] B_ACK  = BW'(P_ACK);
   localparam logic [BW-1:0] B_DAT  = BW'(P_DAT);
   localparam logic [BW-1:0] B_PAR  = BW'(P_PAR);
   localparam logic [BW-1:0] B_LAST = BW'(P_END - 1);

   logic [BW-1:0] bidx;
   logic          phase;
   logic          run;
   logic          hb;
   logic [3:0]    sel_pos;
   logic [2:0]    req_pos;
   logic [1:0]    ack_pos;
   logic [4:0]    dat_pos;

   always_comb begin
      sel_pos = 4'(bidx - B_SEL);
      req_pos = 3'(bidx - B_REQ);
      ack_pos = 2'(bidx - B_ACK);
      dat_pos = 5'(bidx - B_DAT);
      hb      = 1'b1;
      if (bidx >= B_SEL && bidx < B_RST2)      hb = SEL_SEQ[sel_pos];
      else if (bidx >= B_IDLE && bidx < B_REQ) hb = 1'b0;
      else if (bidx >= B_REQ && bidx < B_TRN)  hb = ID_REQ[req_pos];
   end

   assign active  = run;
   assign sclk    = phase;
   assign sdo_low = run && (bidx < B_TRN) && !hb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= 1'b0;
         bidx  <= '0;
         phase <= 1'b0;
         fin   <= 1'b0;
         ack   <= '0;
         id    <= '0;
         par   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go && !run) begin
            run   <= 1'b1;
            bidx  <= '0;
            phase <= 1'b0;
            ack   <= '0;
            id    <= '0;
            par   <= 1'b0;
         end else if (run) begin
            if (!phase) begin
               phase <= 1'b1;
               if (bidx >= B_ACK && bidx < B_DAT)      ack[ack_pos] <= sdi;
               else if (bidx >= B_DAT && bidx < B_PAR) id[dat_pos]  <= sdi;
               else if (bidx == B_PAR)                 par          <= sdi;
            end else begin
               phase <= 1'b0;
               if (bidx == B_LAST) begin
                  run <= 1'b0;
                  fin <= 1'b1;
               end else begin
                  bidx <= bidx + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/dps_pin_route.sv
module dps_pin_route #(
   parameter int NPINS = 8,
   parameter int IDXW  = 3
) (
   input  logic             active,
   input  logic             sclk,
   input  logic             sdo_low,
   input  logic [IDXW-1:0]  c,
   input  logic [IDXW-1:0]  d,
   output logic [NPINS-1:0] pin_oe,
   output logic [NPINS-1:0] pin_out
);
   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic is_c, is_d;
      assign is_c       = (c == IDXW'(p));
      assign is_d       = (d == IDXW'(p));
      assign pin_oe[p]  = active && (is_c || (is_d && sdo_low));
      assign pin_out[p] = active && is_c && sclk;
   end
endmodule

// File: rtl/dbg_pair_scanner.sv
module dbg_pair_scanner
   import dps_pkg::*;
#(
   parameter int NPINS      = 8,
   parameter int IDXW       = $clog2(NPINS),
   parameter int PCW        = 8,
   parameter int SETTLE_W   = 8,
   parameter int RESET_BITS = 56,
   parameter int IDLE_BITS  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [PCW-1:0]      pin_count,
   input  logic [SETTLE_W-1:0] settle_cycles,
   input  logic [NPINS-1:0]    pin_in,
   output logic [NPINS-1:0]    pin_oe,
   output logic [NPINS-1:0]    pin_out,
   output logic                done,
   output logic                found,
   output logic [IDXW-1:0]     clk_idx,
   output logic [IDXW-1:0]     dat_idx,
   output logic [ID_W-1:0]     id_value
);
   if (NPINS < 2) begin : g_bad_npins
      $error("NPINS must be at least 2");
   end
   if (IDXW != $clog2(NPINS)) begin : g_bad_idxw
      $error("IDXW must equal clog2(NPINS)");
   end
   if (PCW < IDXW + 1) begin : g_bad_pcw
      $error("PCW too narrow for NPINS");
   end
   if (RESET_BITS < MIN_RESET_BITS) begin : g_bad_reset
      $error("RESET_BITS below the line reset minimum");
   end
   if (IDLE_BITS < 1) begin : g_bad_idle
      $error("IDLE_BITS must be at least 1");
   end

   scan_state_t         state;
   logic [IDXW:0]       n_q, n_clamp;
   logic [SETTLE_W-1:0] wait_q;
   logic                go, pc_load, pc_adv, last, pass;
   logic                eng_active, eng_sclk, eng_low, eng_fin, eng_par;
   logic [2:0]          eng_ack;
   logic [ID_W-1:0]     eng_id;
   logic                sdi;

   assign n_clamp = (pin_count > PCW'(NPINS)) ? (IDXW+1)'(NPINS) : pin_count[IDXW:0];
   assign sdi     = pin_in[dat_idx];
   assign go      = (state == SC_SETTLE) && (wait_q == '0);
   assign pc_load = ((state == SC_IDLE) || (state == SC_DONE)) && start;
   assign pass    = (eng_ack == ACK_OK) && (eng_par == ^eng_id) &&
                    (eng_id != '0) && (eng_id != '1);
   assign pc_adv  = (state == SC_JUDGE) && !pass && !last;

   dps_pair_cnt #(.NPINS(NPINS), .IDXW(IDXW)) pair_i (
      .clk  (clk),
      .rst_n(rst_n),
      .load (pc_load),
      .adv  (pc_adv),
      .n    (n_q),
      .c    (clk_idx),
      .d    (dat_idx),
      .last (last)
   );

   dps_probe #(.RESET_BITS(RESET_BITS), .IDLE_BITS(IDLE_BITS)) probe_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (go),
      .sdi    (sdi),
      .active (eng_active),
      .sclk   (eng_sclk),
      .sdo_low(eng_low),
      .fin    (eng_fin),
      .ack    (eng_ack),
      .id     (eng_id),
      .par    (eng_par)
   );

   dps_pin_route #(.NPINS(NPINS), .IDXW(IDXW)) route_i (
      .active (eng_active),
      .sclk   (eng_sclk),
      .sdo_low(eng_low),
      .c      (clk_idx),
      .d      (dat_idx),
      .pin_oe (pin_oe),
      .pin_out(pin_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SC_IDLE;
         done     <= 1'b0;
         found    <= 1'b0;
         id_value <= '0;
         n_q      <= '0;
         wait_q   <= '0;
      end else begin
         case (state)
            SC_IDLE, SC_DONE: begin
               if (start) begin
                  done     <= 1'b0;
                  found    <= 1'b0;
                  id_value <= '0;
                  n_q      <= n_clamp;
                  if (n_clamp < (IDXW+1)'(2)) begin
                     state <= SC_DONE;
                     done  <= 1'b1;
                  end else begin
                     state  <= SC_SETTLE;
                     wait_q <= settle_cycles;
                  end
               end
            end
            SC_SETTLE: begin
               if (wait_q == '0) state <= SC_PROBE;
               else              wait_q <= wait_q - 1'b1;
            end
            SC_PROBE: begin
               if (eng_fin) state <= SC_JUDGE;
            end
            SC_JUDGE: begin
               if (pass) begin
                  state    <= SC_DONE;
                  done     <= 1'b1;
                  found    <= 1'b1;
                  id_value <= eng_id;
               end else if (last) begin
                  state <= SC_DONE;
                  done  <= 1'b1;
               end else begin
                  state  <= SC_SETTLE;
                  wait_q <= settle_cycles;
               end
            end
            default: state <= SC_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
   parameter int NPINS = 8,
   parameter int IDXW  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [NPINS-1:0] pin_oe,
   input logic [NPINS-1:0] pin_out,
   input logic             done,
   input logic             found,
   input logic [IDXW-1:0]  clk_idx,
   input logic [IDXW-1:0]  dat_idx,
   input logic [31:0]      id_value
);
   a_r3_two_pins_max: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pin_oe) <= 2);

   a_r3_open_drain_data: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pin_oe & pin_out) <= 1);

   a_r2_distinct_pair: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (clk_idx != dat_idx));

   a_r7_plausible_id: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> ((id_value != '0) && (id_value != '1)));

   a_r9_no_id_when_absent: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !found) |-> (id_value == '0));

   a_r12_released_when_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pin_oe == '0));

   a_r11_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(found) && $stable(id_value)
                            && $stable(clk_idx) && $stable(dat_idx)));
endmodule

bind dbg_pair_scanner dps_checker #(.NPINS(NPINS), .IDXW(IDXW)) chk_i (.*);

// File: tb/dbg_pair_scanner_tb_top.sv
module dbg_pair_scanner_tb_top;
   localparam int NP = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [7:0]    pin_count = '0;
   logic [7:0]    settle_cycles = '0;
   logic [NP-1:0] pin_in, pin_oe, pin_out, line;
   logic          done, found;
   logic [IW-1:0] clk_idx, dat_idx;
   logic [31:0]   id_value;

   // target model knobs and state
   bit        tgt_on = 1'b0;
   int        tc = 0, td = 1;
   bit [2:0]  tgt_ack = 3'b001;
   bit [31:0] tgt_id = 32'h2BA01477;
   bit        tgt_badpar = 1'b0;
   bit        tgt_low = 1'b0;
   int        tgt_req_cnt = 0;

   int n_checks = 0, n_fail = 0, cycles = 0;

   always #5 clk = ~clk;

   dbg_pair_scanner dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .pin_count(pin_count),
      .settle_cycles(settle_cycles), .pin_in(pin_in), .pin_oe(pin_oe),
      .pin_out(pin_out), .done(done), .found(found), .clk_idx(clk_idx),
      .dat_idx(dat_idx), .id_value(id_value)
   );

   always_comb begin
      for (int p = 0; p < NP; p++)
         line[p] = pin_oe[p] ? pin_out[p] : !(tgt_on && (p == td) && tgt_low);
   end
   assign pin_in = line;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // target: samples its data line on each rising edge of its clock line
   initial begin : target_model
      bit        prev = 1'b1, b;
      bit [65:0] hist = '0;
      bit [7:0]  rq = '0;
      int        stage = 0, ones = 0, k = 0;
      bit        v;
      forever begin
         @(negedge clk);
         if (!tgt_on) begin
            stage = 0; hist = '0; tgt_low = 1'b0; prev = 1'b1;
         end else begin
            if (line[tc] && !prev) begin
               b = line[td];
               case (stage)
                  0: begin
                     hist = {b, hist[65:1]};
                     if (hist[65:50] == 16'hE79E && (&hist[49:0])) begin
                        stage = 1; ones = 0;
                     end
                  end
                  1: begin
                     ones = b ? ones + 1 : 0;
                     if (ones >= 50) begin stage = 2; rq = '0; end
                  end
                  2: begin
                     rq = {b, rq[7:1]};
                     if (rq == 8'hA5) begin stage = 3; k = 0; tgt_req_cnt++; end
                  end
                  default: begin
                     if (k < 3)       v = tgt_ack[k];
                     else if (k < 35) v = tgt_id[k-3];
                     else             v = (^tgt_id) ^ tgt_badpar;
                     tgt_low = (k <= 35) ? !v : 1'b0;
                     if (k >= 36) begin stage = 0; hist = '0; tgt_low = 1'b0; end
                     k++;
                  end
               endcase
            end
            prev = line[tc];
         end
      end
   end

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000) begin
            n_fail++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
         end
      end
   end

   function automatic int eff_n(input int pc);
      return (pc > NP) ? NP : pc;
   endfunction

   function automatic int pair_rank(input int n, input int c, input int d);
      return c * (n - 1) + ((d < c) ? d : d - 1);
   endfunction

   // run one scan and check it; mid >= 0 pulses start again (with pin_count 2) at that cycle
   task automatic scan(input int pc, input int st, input bit exp_found, input int mid, input string tag);
      int  trials = 0, run = 0, minrun = 1 << 30, viol = 0, cyc = 0, n, exp_trials;
      bit  prev_any = 1'b0, any;
      logic [31:0] id_keep;
      tgt_req_cnt = 0;
      @(negedge clk);
      pin_count = 8'(pc); settle_cycles = 8'(st); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && cyc < 30000) begin
         if (cyc == mid) begin start = 1'b1; pin_count = 8'd2; end
         else if (cyc == mid + 1) start = 1'b0;
         if ($countones(pin_oe) > 2 || $countones(pin_oe & pin_out) > 1) viol++;
         any = |pin_oe;
         if (any && !prev_any) begin
            trials++;
            if (run < minrun) minrun = run;
         end
         run = any ? 0 : run + 1;
         prev_any = any;
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      n = eff_n(pc);
      exp_trials = (n < 2) ? 0 : (exp_found ? pair_rank(n, tc, td) + 1 : n * (n - 1));
      check(done == 1'b1, {tag, " R9 done raised"}, done, 1);
      check(found == exp_found, {tag, " R2 found"}, found, exp_found);
      check(trials == exp_trials, {tag, " R2 trial count"}, trials, exp_trials);
      check(viol == 0, {tag, " R3 pin drive rule"}, viol, 0);
      check(pin_oe == '0, {tag, " R12 released when done"}, pin_oe, 0);
      if (trials > 0)
         check(minrun >= st, {tag, " R8 settle gap"}, minrun, st);
      if (exp_found) begin
         check(clk_idx == tc[IW-1:0], {tag, " R2 clock index"}, clk_idx, tc);
         check(dat_idx == td[IW-1:0], {tag, " R2 data index"}, dat_idx, td);
         check(id_value == tgt_id, {tag, " R6 id value"}, id_value, tgt_id);
         check(tgt_req_cnt == 1, {tag, " R4 request decoded"}, tgt_req_cnt, 1);
      end else begin
         check(id_value == '0, {tag, " R9 id zero"}, id_value, 0);
      end
      id_keep = id_value;
      repeat (10) @(negedge clk);
      check(done && found == exp_found && id_value == id_keep, {tag, " R11 result holds"},
            {done, found}, {1'b1, exp_found});
   endtask

   initial begin : main
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      // R1: reset state
      check(done == 1'b0, "R1 done low", done, 0);
      check(found == 1'b0, "R1 found low", found, 0);
      check(pin_oe == '0, "R1 pins released", pin_oe, 0);
      check(id_value == '0, "R1 id zero", id_value, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(done == 1'b0 && pin_oe == '0, "R1 idle after reset", {done, pin_oe}, 0);

      // R2 R4 R5 R6: normal find
      tgt_on = 1'b1; tc = 2; td = 0; tgt_ack = 3'b001; tgt_id = 32'h2BA01477; tgt_badpar = 1'b0;
      scan(4, 5, 1'b1, -1, "find");
      // R10: pin_count 0 and 1 end at once
      scan(0, 3, 1'b0, -1, "R10 zero pins");
      scan(1, 3, 1'b0, -1, "R10 one pin");
      // R9: target outside the searched range
      tc = 5; td = 4;
      scan(4, 2, 1'b0, -1, "R9 absent");
      tgt_on = 1'b0; #1 tgt_on = 1'b1;
      // R5: WAIT and FAULT acknowledges fail
      tc = 1; td = 2; tgt_ack = 3'b010;
      scan(3, 1, 1'b0, -1, "R5 wait");
      check(tgt_req_cnt == 1, "R4 request seen on wait", tgt_req_cnt, 1);
      tgt_ack = 3'b100;
      scan(3, 0, 1'b0, -1, "R5 fault");
      tgt_ack = 3'b001;
      // R7: implausible words
      tgt_id = 32'h0;
      scan(3, 0, 1'b0, -1, "R7 zero id");
      tgt_id = 32'hFFFF_FFFF;
      scan(3, 0, 1'b0, -1, "R7 ones id");
      // R6: parity mismatch
      tgt_id = 32'h1234_5679; tgt_badpar = 1'b1;
      scan(3, 0, 1'b0, -1, "R6 bad parity");
      tgt_badpar = 1'b0;
      // R10: pin_count above NPINS clamps; last pair in order
      tc = 7; td = 6; tgt_id = 32'h0BB1_1477;
      scan(12, 0, 1'b1, -1, "R10 clamp last pair");
      // R11: start mid-scan ignored
      tc = 4; td = 3; tgt_id = 32'h4BA0_0477;
      scan(5, 4, 1'b1, 600, "R11 restart ignored");
      // random pairs
      for (int i = 0; i < 6; i++) begin
         int pc = 2 + int'($urandom_range(4));
         tc = int'($urandom_range(pc - 1));
         do td = int'($urandom_range(pc - 1)); while (td == tc);
         do tgt_id = $urandom; while (tgt_id == 32'h0 || tgt_id == 32'hFFFF_FFFF);
         scan(pc, int'($urandom_range(15)), 1'b1, -1, "R2 random pair");
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule